// File: doc/BRIEF.md
# Segmented Effective Address Generator

This unit forms the offset part of a segmented memory address. It takes an addressing-mode code, the values of a base register and an index register (already read from the register file elsewhere), and an immediate displacement. From these it builds a segment code and an operand offset. The mode code chooses which of the three terms enter the sum. A missing term counts as zero. In the 32-bit operand width the index term can be multiplied by 1, 2, 4 or 8. Short displacements are sign-extended. The sum wraps at the active width.

Segment selection follows the base register. A stack-pointer-class base (BP, or ESP/EBP in 32-bit width) picks the stack segment. Every other case picks the data segment. An override input replaces this choice. A request is presented with a valid strobe. The result appears in a register stage together with an output valid one cycle later.

Top module: `eaddr_gen`

## Requirements
- R1: Mode codes select the terms. 0 gives disp. 1 gives base (register indirect; the pointer register value arrives on the base input). 2 gives base+disp. 3 gives index·s+disp. 4 gives base+index·s. 5 gives base+index·s+disp.
- R2: With `in_disp8`=1, only `in_disp[7:0]` is used, sign-extended from bit 7. With `in_disp8`=0, `in_disp` is used as given.
- R3: Any carry out of the active width is lost. The sum is taken modulo 2^16 when `in_wide`=0 and modulo 2^32 when `in_wide`=1. With `in_wide`=0, `out_offset[31:16]` is zero.
- R4: With `in_wide`=1, the scale field gives s = 1, 2, 4 or 8 for codes 00, 01, 10 and 11. It applies only to the index term.
- R5: With `in_wide`=0, the scale field is ignored and s = 1.
- R6: Segment codes are 0=ES, 1=CS, 2=SS, 3=DS, 4=FS and 5=GS. Without an override, the result is SS when the mode uses a base term (1, 2, 4, 5) and `in_base_id` is 5 (BP), or 4 (SP) with `in_wide`=1. In all other cases it is DS. Register ids are 0..7 = AX, CX, DX, BX, SP, BP, SI, DI.
- R7: With `in_ovr_en`=1, `out_seg` equals `in_ovr_seg`.
- R8: `out_valid` rises on the edge after an edge at which `in_valid`=1, and it is low otherwise. When `in_valid`=0, the `out_offset`, `out_seg` and `out_wide` outputs hold.
- R9: A synchronous active-low reset clears `out_valid`.
- R10: Reserved mode codes 6 and 7 behave as mode 0: disp only, segment DS unless overridden.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe; the inputs are sampled when it is high |
| in_wide | input | 1 | 1 = 32-bit address width, 0 = 16-bit |
| in_mode | input | 3 | Addressing-mode code |
| in_base_id | input | 3 | Register number of the base/pointer register |
| in_base | input | 32 | Base register value |
| in_index | input | 32 | Index register value |
| in_disp | input | 32 | Displacement |
| in_disp8 | input | 1 | Displacement is 8-bit, sign-extended |
| in_scale | input | 2 | Index scale code |
| in_ovr_en | input | 1 | Segment override enable |
| in_ovr_seg | input | 3 | Override segment code |
| out_valid | output | 1 | Result valid |
| out_offset | output | 32 | Computed offset |
| out_seg | output | 3 | Segment code |
| out_wide | output | 1 | Width of the registered result |

## Verification
The sweep covers every mode code, both widths, all four scale codes and both displacement sizes. It uses operand patterns chosen to overflow both widths. A design that kept the carry or masked at the wrong width would leak bits above bit 15 or miss the wrap. A design that zero-extended an 8-bit displacement would be off by 256 for negative bytes. A separate sweep crosses every base register id with every mode and both widths. Scaling the index in 16-bit mode or treating SP as a stack base in 16-bit mode would show up as wrong offsets or a wrong segment. The bench also checks that a cleared strobe leaves the held result untouched. It checks that reset suppresses the output valid even while requests are present.

// File: rtl/eag_pkg.sv
// Package: shared widths and code points of the effective address generator.
// Assumes 3-bit mode, register-id and segment codes.
package eag_pkg;
    localparam int EA_W      = 32;  // widest offset
    localparam int EA_NW     = 16;  // narrow offset
    localparam int EA_SCW    = 2;   // scale code width
    localparam int EA_DSW    = 8;   // short displacement width
    localparam int EA_MODE_W = 3;
    localparam int EA_RID_W  = 3;
    localparam int EA_SEG_W  = 3;

    localparam int MODE_DIRECT   = 0;
    localparam int MODE_REGIND   = 1;
    localparam int MODE_BASED    = 2;
    localparam int MODE_INDEXED  = 3;
    localparam int MODE_BASEIDX  = 4;
    localparam int MODE_BASEIDXD = 5;

    localparam int RID_SP = 4;
    localparam int RID_BP = 5;

    localparam int SEG_SS = 2;
    localparam int SEG_DS = 3;
endpackage

// File: rtl/eag_terms.sv
// Term selector: decodes the mode and produces the three addends already
// extended, scaled and masked to the active width. Unused terms are zero.
// Assumes unknown mode codes act as displacement-only.
module eag_terms
    import eag_pkg::*;
#(
    parameter int AW  = EA_W,
    parameter int NW  = EA_NW,
    parameter int SCW = EA_SCW,
    parameter int DSW = EA_DSW,
    parameter int MW  = EA_MODE_W
) (
    input  logic [MW-1:0]  mode,
    input  logic           wide,
    input  logic [AW-1:0]  base_val,
    input  logic [AW-1:0]  index_val,
    input  logic [AW-1:0]  disp,
    input  logic           disp_short,
    input  logic [SCW-1:0] scale,
    output logic [AW-1:0]  base_t,
    output logic [AW-1:0]  index_t,
    output logic [AW-1:0]  disp_t,
    output logic           uses_base
);
    localparam int NSH = 1 << SCW;
    localparam logic [AW-1:0] NARROW_MASK = {{(AW-NW){1'b0}}, {NW{1'b1}}};

    logic          use_b, use_i, use_d;
    logic [AW-1:0] mask;
    logic [AW-1:0] disp_ext;
    logic [SCW-1:0] eff_scale;
    logic [AW-1:0] shifted [NSH];

    // Decode which terms the mode adds.
    always_comb begin
        use_b = 1'b0;
        use_i = 1'b0;
        use_d = 1'b0;
        case (int'(mode))
            MODE_REGIND:   use_b = 1'b1;
            MODE_BASED:    begin use_b = 1'b1; use_d = 1'b1; end
            MODE_INDEXED:  begin use_i = 1'b1; use_d = 1'b1; end
            MODE_BASEIDX:  begin use_b = 1'b1; use_i = 1'b1; end
            MODE_BASEIDXD: begin use_b = 1'b1; use_i = 1'b1; use_d = 1'b1; end
            default:       use_d = 1'b1;
        endcase
    end

    // Pre-shifted index copies, one per scale code.
    for (genvar g = 0; g < NSH; g++) begin : g_shift
        assign shifted[g] = index_val << g;
    end

    // Width mask, displacement extension and scale choice.
    always_comb begin
        mask      = wide ? {AW{1'b1}} : NARROW_MASK;
        disp_ext  = disp_short ? {{(AW-DSW){disp[DSW-1]}}, disp[DSW-1:0]} : disp;
        eff_scale = wide ? scale : '0;
    end

    // Gate and mask each addend.
    always_comb begin
        base_t    = use_b ? (base_val & mask) : '0;
        index_t   = use_i ? (shifted[eff_scale] & mask) : '0;
        disp_t    = use_d ? (disp_ext & mask) : '0;
        uses_base = use_b;
    end
endmodule

// File: rtl/eag_sum.sv
// Three-input offset adder. The carry above the active width is dropped.
// Assumes the addends are already masked to the active width.
module eag_sum
    import eag_pkg::*;
#(
    parameter int AW = EA_W,
    parameter int NW = EA_NW
) (
    input  logic          wide,
    input  logic [AW-1:0] a,
    input  logic [AW-1:0] b,
    input  logic [AW-1:0] c,
    output logic [AW-1:0] sum
);
    localparam logic [AW-1:0] NARROW_MASK = {{(AW-NW){1'b0}}, {NW{1'b1}}};

    logic [AW-1:0] raw;

    // Add at full width, then clip to the active width.
    always_comb begin
        raw = a + b + c;
        sum = wide ? raw : (raw & NARROW_MASK);
    end
endmodule

// File: rtl/eag_seg.sv
// Segment chooser: the stack segment for stack-pointer-class bases, the data
// segment otherwise, or the override when it is enabled.
// Assumes register ids follow the accumulator-first numbering.
module eag_seg
    import eag_pkg::*;
#(
    parameter int RIW = EA_RID_W,
    parameter int SW  = EA_SEG_W
) (
    input  logic           uses_base,
    input  logic           wide,
    input  logic [RIW-1:0] base_id,
    input  logic           ovr_en,
    input  logic [SW-1:0]  ovr_seg,
    output logic [SW-1:0]  seg
);
    logic stack_base;

    // Pick the default segment, then apply any override.
    always_comb begin
        stack_base = uses_base &&
                     ((base_id == RIW'(RID_BP)) || (wide && base_id == RIW'(RID_SP)));
        if (ovr_en)
            seg = ovr_seg;
        else if (stack_base)
            seg = SW'(SEG_SS);
        else
            seg = SW'(SEG_DS);
    end
endmodule

// File: rtl/eaddr_gen.sv
// Top of the effective address generator: term selection, addition and
// segment choice feed one output register stage with a valid flag.
// Assumes the register values arrive together with in_valid.
module eaddr_gen
    import eag_pkg::*;
#(
    parameter int AW  = EA_W,
    parameter int NW  = EA_NW,
    parameter int SCW = EA_SCW,
    parameter int DSW = EA_DSW,
    parameter int MW  = EA_MODE_W,
    parameter int RIW = EA_RID_W,
    parameter int SW  = EA_SEG_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic           in_wide,
    input  logic [MW-1:0]  in_mode,
    input  logic [RIW-1:0] in_base_id,
    input  logic [AW-1:0]  in_base,
    input  logic [AW-1:0]  in_index,
    input  logic [AW-1:0]  in_disp,
    input  logic           in_disp8,
    input  logic [SCW-1:0] in_scale,
    input  logic           in_ovr_en,
    input  logic [SW-1:0]  in_ovr_seg,
    output logic           out_valid,
    output logic [AW-1:0]  out_offset,
    output logic [SW-1:0]  out_seg,
    output logic           out_wide
);
    logic [AW-1:0] base_t, index_t, disp_t, sum;
    logic          uses_base;
    logic [SW-1:0] seg;

    eag_terms #(.AW(AW), .NW(NW), .SCW(SCW), .DSW(DSW), .MW(MW)) u_terms (
        .mode       (in_mode),
        .wide       (in_wide),
        .base_val   (in_base),
        .index_val  (in_index),
        .disp       (in_disp),
        .disp_short (in_disp8),
        .scale      (in_scale),
        .base_t     (base_t),
        .index_t    (index_t),
        .disp_t     (disp_t),
        .uses_base  (uses_base)
    );

    eag_sum #(.AW(AW), .NW(NW)) u_sum (
        .wide (in_wide),
        .a    (base_t),
        .b    (index_t),
        .c    (disp_t),
        .sum  (sum)
    );

    eag_seg #(.RIW(RIW), .SW(SW)) u_seg (
        .uses_base (uses_base),
        .wide      (in_wide),
        .base_id   (in_base_id),
        .ovr_en    (in_ovr_en),
        .ovr_seg   (in_ovr_seg),
        .seg       (seg)
    );

    // Valid flag: follows the strobe one cycle later and is cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else
            out_valid <= in_valid;
    end

    // Result register: loads only on an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_offset <= '0;
            out_seg    <= SW'(SEG_DS);
            out_wide   <= 1'b0;
        end else if (in_valid) begin
            out_offset <= sum;
            out_seg    <= seg;
            out_wide   <= in_wide;
        end
    end

    // R8: the output valid tracks the strobe with one cycle of delay.
    p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_offset) && $stable(out_seg)));

    // R9: reset empties the output stage.
    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R7: the override reaches the segment output.
    p_override_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ovr_en) |=> (out_seg == $past(in_ovr_seg)));

    // R3: a narrow result never carries bits above the narrow width.
    p_narrow_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_wide) |-> (out_offset[AW-1:NW] == '0));

    // R5: in narrow width the index term is the raw, unscaled low index.
    p_narrow_unscaled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_wide && int'(in_mode) == MODE_INDEXED)
        |-> (index_t == {{(AW-NW){1'b0}}, in_index[NW-1:0]}));

    // R1: direct mode contributes neither base nor index.
    p_direct_terms_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && int'(in_mode) == MODE_DIRECT) |-> (base_t == '0 && index_t == '0));
endmodule

// File: tb/eaddr_gen_test.sv
`timescale 1ns/1ps
module eaddr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_wide = 1'b0;
    logic [2:0]  in_mode = '0;
    logic [2:0]  in_base_id = '0;
    logic [31:0] in_base = '0, in_index = '0, in_disp = '0;
    logic        in_disp8 = 1'b0;
    logic [1:0]  in_scale = '0;
    logic        in_ovr_en = 1'b0;
    logic [2:0]  in_ovr_seg = '0;
    logic        out_valid;
    logic [31:0] out_offset;
    logic [2:0]  out_seg;
    logic        out_wide;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    eaddr_gen uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_wide(in_wide),
        .in_mode(in_mode), .in_base_id(in_base_id), .in_base(in_base),
        .in_index(in_index), .in_disp(in_disp), .in_disp8(in_disp8),
        .in_scale(in_scale), .in_ovr_en(in_ovr_en), .in_ovr_seg(in_ovr_seg),
        .out_valid(out_valid), .out_offset(out_offset), .out_seg(out_seg),
        .out_wide(out_wide)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit uses_b(input int m);
        return (m == 1 || m == 2 || m == 4 || m == 5);
    endfunction
    function automatic bit uses_i(input int m);
        return (m == 3 || m == 4 || m == 5);
    endfunction
    function automatic bit uses_d(input int m);
        return (m == 0 || m == 2 || m == 3 || m == 5 || m >= 6);
    endfunction

    // Arithmetic reference of the offset: signed sum reduced modulo the width.
    function automatic logic [31:0] ref_off(input bit w, input int m,
        input logic [31:0] b, input logic [31:0] x, input logic [31:0] d,
        input bit s8, input int sc);
        longint modv, dv, sum;
        modv = w ? 64'sd4294967296 : 64'sd65536;
        dv   = s8 ? longint'($signed(d[7:0])) : longint'(d);
        sum  = 0;
        if (uses_b(m)) sum += longint'(b);
        if (uses_i(m)) sum += longint'(x) * (w ? (64'sd1 << sc) : 64'sd1);
        if (uses_d(m)) sum += dv;
        sum = ((sum % modv) + modv) % modv;
        return sum[31:0];
    endfunction

    function automatic logic [2:0] ref_seg(input bit w, input int m, input int id,
                                           input bit ov, input logic [2:0] os);
        if (ov) return os;
        if (uses_b(m) && (id == 5 || (w && id == 4))) return 3'd2;
        return 3'd3;
    endfunction

    // Apply one request at a falling edge and check it at the next one.
    task automatic run_vec(input bit w, input int m, input int id,
        input logic [31:0] b, input logic [31:0] x, input logic [31:0] d,
        input bit s8, input int sc, input bit ov, input logic [2:0] os,
        input string otag);
        logic [31:0] eo;
        logic [2:0]  es;
        in_valid = 1'b1; in_wide = w; in_mode = 3'(m); in_base_id = 3'(id);
        in_base = b; in_index = x; in_disp = d; in_disp8 = s8;
        in_scale = 2'(sc); in_ovr_en = ov; in_ovr_seg = os;
        eo = ref_off(w, m, b, x, d, s8, sc);
        es = ref_seg(w, m, id, ov, os);
        @(negedge clk);
        chk(out_valid === 1'b1, "R8 valid", 32'(out_valid), 32'd1);
        chk(out_offset === eo, otag, out_offset, eo);
        chk(out_seg === es, ov ? "R7 override" : "R6 default segment",
            32'(out_seg), 32'(es));
        if (!w) chk(out_offset[31:16] === 16'h0, "R3 narrow high bits",
                    32'(out_offset[31:16]), 32'd0);
    endtask

    task automatic pattern(input int p, output logic [31:0] b, output logic [31:0] x,
                           output logic [31:0] d);
        case (p)
            0: begin b = 32'h0000_1234; x = 32'h0000_0101; d = 32'h0000_0010; end
            1: begin b = 32'hFFFF_FFF0; x = 32'h0000_0008; d = 32'h0000_0080; end
            2: begin b = 32'h8000_FFFF; x = 32'hFFFF_FFFF; d = 32'hFFFF_FF00; end
            3: begin b = 32'h0000_0000; x = 32'h4000_0001; d = 32'h0000_007F; end
            4: begin b = 32'h0001_FFFE; x = 32'h0000_C000; d = 32'h0000_8001; end
            default: begin b = 32'hDEAD_BEEF; x = 32'h1357_9BDF; d = 32'hA5A5_5A7E; end
        endcase
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] b, x, d, held;
        string tag;
        // R9: requests during reset never raise the output valid.
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0, "R9 reset clears valid", 32'(out_valid), 32'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b0, "R8 idle after reset", 32'(out_valid), 32'd0);

        // Main sweep over width, mode, scale, displacement size and data pattern.
        for (int w = 0; w < 2; w++)
            for (int m = 0; m < 8; m++)
                for (int sc = 0; sc < 4; sc++)
                    for (int s8 = 0; s8 < 2; s8++)
                        for (int p = 0; p < 6; p++) begin
                            pattern(p, b, x, d);
                            if (m >= 6) tag = "R10 reserved mode";
                            else if (p == 2) tag = "R3 carry wrap";
                            else if (w == 0 && sc != 0 && uses_i(m)) tag = "R5 narrow scale ignored";
                            else if (w == 1 && sc != 0 && uses_i(m)) tag = "R4 scaled index";
                            else if (s8 == 1) tag = "R2 short displacement";
                            else tag = "R1 mode terms";
                            run_vec(w[0], m, (p + sc) % 8, b, x, d, s8[0], sc,
                                    (p == 5), 3'((m + sc) % 6), tag);
                        end

        // Segment sweep: every register id with every mode, with and without override.
        for (int w = 0; w < 2; w++)
            for (int m = 0; m < 8; m++)
                for (int id = 0; id < 8; id++)
                    for (int ov = 0; ov < 2; ov++)
                        run_vec(w[0], m, id, 32'h0000_2000, 32'h0000_0040, 32'h0000_0004,
                                1'b0, 1, ov[0], 3'((id + m) % 6), "R1 segment sweep offset");

        // R8: with the strobe low, the result holds and valid falls.
        run_vec(1'b1, 5, 3, 32'h1000_0000, 32'h0000_0100, 32'h0000_0003, 1'b0, 3,
                1'b0, 3'd0, "R4 before hold");
        held = out_offset;
        in_valid = 1'b0;
        in_base = 32'hFFFF_0000; in_mode = 3'd2; in_ovr_en = 1'b1; in_ovr_seg = 3'd5;
        @(negedge clk);
        chk(out_valid === 1'b0, "R8 valid drops", 32'(out_valid), 32'd0);
        chk(out_offset === held, "R8 offset holds", out_offset, held);
        chk(out_seg === 3'd3, "R8 segment holds", 32'(out_seg), 32'd3);
        @(negedge clk);
        chk(out_offset === held, "R8 offset still held", out_offset, held);

        // R9: reset mid-stream with requests present.
        in_valid = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        chk(out_valid === 1'b0, "R9 reset mid-run", 32'(out_valid), 32'd0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule